// File: doc/BRIEF.md
# Debug Memory Access Port

This block sits behind a debug port and gives an external debugger a window onto a 32-bit internal memory bus. The debug port issues single register reads and writes. Each one carries a 4-bit port number, a 4-bit bank number and a 2-bit word number. Only requests whose port number matches the configured `PORT_NUM` are served. The bank and word numbers form an 8-bit register address: the bank sits in bits [7:4], the word in bits [3:2], and bits [1:0] are zero.

Internally the block holds a mode word and a 32-bit target address. Touching the direct data register, or any of four banked data registers, starts exactly one bus transfer. The banked registers cover a 16-byte window aligned by the target address. Data reads are posted: the debugger gets the result of the previous bus read, and the new read value lands in a read buffer once the bus completes it. A busy bit shows that a transfer is in flight, and accesses that would disturb that transfer are refused with a WAIT.

The request side has no back-pressure. A request is a single-cycle `dp_valid` pulse, and a matched request is always answered one cycle later with `dp_rsp_valid`. The bus side is valid/ready. `mb_valid` rises with the address, write flag and write data. All four stay constant until the cycle in which `mb_ready` is high. That cycle completes the transfer, and for a read `mb_rdata` is sampled in that same cycle.

Top module: `dbg_mem_port`

## Requirements
- R1: A request whose port number differs from `PORT_NUM` gets no response, starts no bus transfer and changes no register. A matched request is decoded at the address {bank, word, 2'b00}.
- R2: The mode word is at address 0x00. A read returns the mode in bits [1:0] and the busy flag in bit 7, with all other bits zero. A write stores `dp_wdata[1:0]` as the mode. The mode is 0 after reset.
- R3: The target address register is at 0x04 and can be read and written as 32 bits. It is 0 after reset.
- R4: A read or write of 0x0C starts one bus transfer at the full target address. A write carries `dp_wdata` on the bus.
- R5: A read or write of 0x10, 0x14, 0x18 or 0x1C starts one bus transfer at {target[31:4], word, 2'b00}, giving low nibbles 0x0, 0x4, 0x8 and 0xC. Such transfers never change the target address.
- R6: 0xF8 reads as `ROM_BASE` and 0xFC reads as `ID_VALUE`. Writes to either have no effect.
- R7: The reserved addresses (0x08, 0x20 to 0xEC, 0xF0 and 0xF4) read as zero. Writes to them change nothing and start no transfer.
- R8: A read of a data register returns the read buffer as it stood before this request. The read buffer is 0 after reset and takes `mb_rdata` when a bus read completes.
- R9: While a transfer is outstanding, any data or banked access, and any write to 0x00 or 0x04, is answered with `dp_rsp_wait`=1 and `dp_rsp_rdata`=0, and has no effect. Reads of other addresses are served normally.
- R10: When the mode is 2'b01, completion of a 0x0C transfer adds 4 to the target address, wrapping modulo 2^32. The other mode values leave the target unchanged.
- R11: `mb_valid`, `mb_addr`, `mb_write` and `mb_wdata` stay stable from launch until the cycle in which `mb_ready` is 1. `mb_valid` is low in the cycle after that.
- R12: `dp_rsp_valid` is high exactly in the cycle after a matched request. A write response, or a refused request, carries `dp_rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_valid | input | 1 | Single-cycle request strobe |
| dp_write | input | 1 | 1 for a write, 0 for a read |
| dp_port | input | 4 | Access-port number of the request |
| dp_bank | input | 4 | Bank number, address bits [7:4] |
| dp_word | input | 2 | Word number, address bits [3:2] |
| dp_wdata | input | 32 | Write data |
| dp_rsp_valid | output | 1 | Response strobe, one cycle after a matched request |
| dp_rsp_wait | output | 1 | Request refused because a transfer is in flight |
| dp_rsp_rdata | output | 32 | Read data |
| mb_valid | output | 1 | Bus transfer request |
| mb_ready | input | 1 | Bus accepts and completes the transfer |
| mb_write | output | 1 | Bus transfer is a write |
| mb_addr | output | 32 | Bus byte address |
| mb_wdata | output | 32 | Bus write data |
| mb_rdata | input | 32 | Bus read data, valid while mb_ready is 1 |

## Verification
Most internal faults show up at the debug port within one request. A bad target address or bank decode shows on `mb_addr` in the cycle after the request. A stale or wrong read buffer shows on the next posted data read. A wrong busy flag appears as a missing or spurious WAIT on the very next data access. A faulty increment shows up only at the next target-address read or bus launch. For that reason the bench checks `mb_addr` on every launch and reads the target register back at random.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  typedef enum logic [2:0] {
    CL_MODE, CL_TARGET, CL_DATA, CL_BANK, CL_BASE, CL_IDENT, CL_NONE
  } reg_cls_t;

  localparam logic [7:0] A_MODE   = 8'h00;
  localparam logic [7:0] A_TARGET = 8'h04;
  localparam logic [7:0] A_DATA   = 8'h0C;
  localparam logic [7:0] A_BASE   = 8'hF8;
  localparam logic [7:0] A_IDENT  = 8'hFC;
  localparam logic [3:0] BANK_WIN = 4'h1;
  localparam logic [1:0] MODE_INC = 2'b01;
endpackage

// File: rtl/dmp_decode.sv
module dmp_decode
  import dmp_pkg::*;
(
  input  logic [3:0] bank,
  input  logic [1:0] word,
  output reg_cls_t   cls
);
  logic [7:0] addr;

  always_comb begin
    addr = {bank, word, 2'b00};
    if (bank == BANK_WIN)        cls = CL_BANK;
    else if (addr == A_MODE)     cls = CL_MODE;
    else if (addr == A_TARGET)   cls = CL_TARGET;
    else if (addr == A_DATA)     cls = CL_DATA;
    else if (addr == A_BASE)     cls = CL_BASE;
    else if (addr == A_IDENT)    cls = CL_IDENT;
    else                         cls = CL_NONE;
  end
endmodule

// File: rtl/dmp_bus_seq.sv
module dmp_bus_seq #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          launch_wr,
  input  logic          launch_inc,
  input  logic [AW-1:0] launch_addr,
  input  logic [DW-1:0] launch_wdata,
  input  logic          mb_ready,
  output logic          mb_valid,
  output logic          mb_write,
  output logic [AW-1:0] mb_addr,
  output logic [DW-1:0] mb_wdata,
  output logic          done,
  output logic          done_inc,
  output logic          done_rd
);
  logic inc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mb_valid <= 1'b0;
      mb_write <= 1'b0;
      mb_addr  <= '0;
      mb_wdata <= '0;
      inc_q    <= 1'b0;
    end else if (launch) begin
      mb_valid <= 1'b1;
      mb_write <= launch_wr;
      mb_addr  <= launch_addr;
      mb_wdata <= launch_wr ? launch_wdata : '0;
      inc_q    <= launch_inc;
    end else if (mb_valid && mb_ready) begin
      mb_valid <= 1'b0;
    end
  end

  assign done     = mb_valid && mb_ready;
  assign done_inc = done && inc_q;
  assign done_rd  = done && !mb_write;

  // R11: request held steady until accepted
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_valid && !mb_ready) |=> (mb_valid && $stable(mb_addr) && $stable(mb_wdata) && $stable(mb_write)));
  a_r11_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_valid && mb_ready && !launch) |=> !mb_valid);
  // R9: never launch over an outstanding transfer
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !mb_valid);
endmodule

// File: rtl/dbg_mem_port.sv
module dbg_mem_port
  import dmp_pkg::*;
#(
  parameter logic [3:0]  PORT_NUM = 4'h0,
  parameter logic [31:0] ROM_BASE = 32'hF00F_0003,
  parameter logic [31:0] ID_VALUE = 32'h0477_0031
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dp_valid,
  input  logic        dp_write,
  input  logic [3:0]  dp_port,
  input  logic [3:0]  dp_bank,
  input  logic [1:0]  dp_word,
  input  logic [31:0] dp_wdata,
  output logic        dp_rsp_valid,
  output logic        dp_rsp_wait,
  output logic [31:0] dp_rsp_rdata,
  output logic        mb_valid,
  input  logic        mb_ready,
  output logic        mb_write,
  output logic [31:0] mb_addr,
  output logic [31:0] mb_wdata,
  input  logic [31:0] mb_rdata
);
  localparam int AW = 32;
  localparam int DW = 32;

  reg_cls_t      cls;
  logic [1:0]    mode;
  logic [AW-1:0] target;
  logic [DW-1:0] rbuf;
  logic          hit, is_data, blocked, launch, busy;
  logic          done, done_inc, done_rd;
  logic [AW-1:0] launch_addr;
  logic [DW-1:0] read_val;

  dmp_decode u_dec (.bank(dp_bank), .word(dp_word), .cls(cls));

  assign busy        = mb_valid;
  assign hit         = dp_valid && (dp_port == PORT_NUM);
  assign is_data     = (cls == CL_DATA) || (cls == CL_BANK);
  assign blocked     = busy && (is_data || (dp_write && (cls == CL_MODE || cls == CL_TARGET)));
  assign launch      = hit && is_data && !busy;
  assign launch_addr = (cls == CL_BANK) ? {target[AW-1:4], dp_word, 2'b00} : target;

  always_comb begin
    case (cls)
      CL_MODE:         read_val = {24'h0, busy, 5'h0, mode};
      CL_TARGET:       read_val = target;
      CL_DATA, CL_BANK: read_val = rbuf;
      CL_BASE:         read_val = ROM_BASE;
      CL_IDENT:        read_val = ID_VALUE;
      default:         read_val = '0;
    endcase
  end

  dmp_bus_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .launch_wr(dp_write),
    .launch_inc((cls == CL_DATA) && (mode == MODE_INC)),
    .launch_addr(launch_addr), .launch_wdata(dp_wdata),
    .mb_ready(mb_ready), .mb_valid(mb_valid), .mb_write(mb_write),
    .mb_addr(mb_addr), .mb_wdata(mb_wdata),
    .done(done), .done_inc(done_inc), .done_rd(done_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= 2'b00;
      target <= '0;
      rbuf   <= '0;
    end else begin
      if (hit && dp_write && !blocked && cls == CL_MODE)   mode   <= dp_wdata[1:0];
      if (hit && dp_write && !blocked && cls == CL_TARGET) target <= dp_wdata;
      if (done_inc) target <= target + 32'd4;
      if (done_rd)  rbuf   <= mb_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_rsp_valid <= 1'b0;
      dp_rsp_wait  <= 1'b0;
      dp_rsp_rdata <= '0;
    end else begin
      dp_rsp_valid <= hit;
      dp_rsp_wait  <= hit && blocked;
      dp_rsp_rdata <= (hit && !dp_write && !blocked) ? read_val : '0;
    end
  end

  // R12: response exactly one cycle after a matched request
  a_r12_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> dp_rsp_valid);
  a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !dp_rsp_valid);
  // R5 / R10: only an incrementing completion may move the target while busy
  a_r5_target_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_inc) |=> $stable(target));
  // R1: unmatched request never launches a transfer
  a_r1_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && dp_port != PORT_NUM && !mb_valid) |=> !mb_valid);
endmodule

// File: tb/sim_dbg_mem_port.sv
module sim_dbg_mem_port;
  localparam logic [3:0]  PN   = 4'h0;
  localparam logic [31:0] BASE = 32'hF00F_0003;
  localparam logic [31:0] IDV  = 32'h0477_0031;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dp_valid = 0, dp_write = 0;
  logic [3:0] dp_port = 0, dp_bank = 0;
  logic [1:0] dp_word = 0;
  logic [31:0] dp_wdata = 0;
  logic dp_rsp_valid, dp_rsp_wait;
  logic [31:0] dp_rsp_rdata;
  logic mb_valid, mb_write, mb_ready = 0;
  logic [31:0] mb_addr, mb_wdata, mb_rdata = 0;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [1:0]  m_mode = 0;
  logic [31:0] m_tar = 0, m_rbuf = 0;

  always #4 clk = ~clk;

  dbg_mem_port #(.PORT_NUM(PN), .ROM_BASE(BASE), .ID_VALUE(IDV)) u0 (
    .clk(clk), .rst_n(rst_n), .dp_valid(dp_valid), .dp_write(dp_write),
    .dp_port(dp_port), .dp_bank(dp_bank), .dp_word(dp_word), .dp_wdata(dp_wdata),
    .dp_rsp_valid(dp_rsp_valid), .dp_rsp_wait(dp_rsp_wait), .dp_rsp_rdata(dp_rsp_rdata),
    .mb_valid(mb_valid), .mb_ready(mb_ready), .mb_write(mb_write), .mb_addr(mb_addr),
    .mb_wdata(mb_wdata), .mb_rdata(mb_rdata));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request; returns at the negedge after the response edge
  task automatic req(bit wr, logic [3:0] port, logic [7:0] addr, logic [31:0] wd);
    dp_valid = 1; dp_write = wr; dp_port = port;
    dp_bank = addr[7:4]; dp_word = addr[3:2]; dp_wdata = wd;
    @(posedge clk); @(negedge clk);
    dp_valid = 0;
  endtask

  task automatic serve(int lat, logic [31:0] rd);
    logic [31:0] a0 = mb_addr;
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      check("R11 hold valid", {31'b0, mb_valid}, 32'd1);
      check("R11 hold addr", mb_addr, a0);
    end
    mb_ready = 1; mb_rdata = rd;
    @(posedge clk); @(negedge clk);
    mb_ready = 0; mb_rdata = 0;
    check("R11 drop valid", {31'b0, mb_valid}, 32'd0);
  endtask

  function automatic logic [31:0] exp_read(logic [7:0] a, bit busy);
    case (a)
      8'h00: return {24'h0, busy, 5'h0, m_mode};
      8'h04: return m_tar;
      8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C: return m_rbuf;
      8'hF8: return BASE;
      8'hFC: return IDV;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit is_data(logic [7:0] a);
    return (a == 8'h0C) || (a[7:4] == 4'h1);
  endfunction

  function automatic logic [7:0] pick_addr(int k);
    case (k)
      0: return 8'h00;  1: return 8'h04;  2: return 8'h0C;  3: return 8'h10;
      4: return 8'h14;  5: return 8'h18;  6: return 8'h1C;  7: return 8'hF8;
      8: return 8'hFC;  9: return 8'h08;  10: return 8'h20; 11: return 8'hF0;
      default: return 8'hF4;
    endcase
  endfunction

  // full access incl. model update; port match assumed
  task automatic access(bit wr, logic [7:0] a, logic [31:0] wd, int lat, logic [31:0] rd);
    logic [31:0] er = wr ? 32'h0 : exp_read(a, 1'b0);
    logic [31:0] ea = (a[7:4] == 4'h1) ? {m_tar[31:4], a[3:0]} : m_tar;
    req(wr, PN, a, wd);
    check("R12 rsp valid", {31'b0, dp_rsp_valid}, 32'd1);
    check("R12 no wait", {31'b0, dp_rsp_wait}, 32'd0);
    check(a[7:4] == 4'h1 ? "R5/R8 rdata" : (a == 8'h0C ? "R4/R8 rdata" :
          (a >= 8'hF8 ? "R6 rdata" : (a == 8'h00 ? "R2 rdata" : (a == 8'h04 ? "R3 rdata" : "R7 rdata")))),
          dp_rsp_rdata, er);
    if (is_data(a)) begin
      check(a[7:4] == 4'h1 ? "R5 launch" : "R4 launch", {31'b0, mb_valid}, 32'd1);
      check(a[7:4] == 4'h1 ? "R5 addr" : "R4 addr", mb_addr, ea);
      check("R4 write flag", {31'b0, mb_write}, {31'b0, wr});
      if (wr) check("R4 wdata", mb_wdata, wd);
      serve(lat, rd);
      if (!wr) m_rbuf = rd;
      if (a == 8'h0C && m_mode == 2'b01) m_tar = m_tar + 32'd4;
    end else begin
      check("R7 no launch", {31'b0, mb_valid}, 32'd0);
      if (wr && a == 8'h00) m_mode = wd[1:0];
      if (wr && a == 8'h04) m_tar = wd;
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R12 reset rsp", {31'b0, dp_rsp_valid}, 32'd0);
    check("R11 reset bus idle", {31'b0, mb_valid}, 32'd0);
    access(0, 8'h00, 0, 0, 0);                 // R2 reset mode
    access(0, 8'h04, 0, 0, 0);                 // R3 reset target
    access(0, 8'h0C, 0, 1, 32'hAAAA_5555);     // R8 first read returns 0
    access(0, 8'h0C, 0, 0, 32'h1234_5678);     // R8 posted: returns previous
    // R6 read-only writes ignored
    access(1, 8'hF8, 32'hFFFF_FFFF, 0, 0);
    access(0, 8'hF8, 0, 0, 0);
    access(1, 8'hFC, 32'h0, 0, 0);
    access(0, 8'hFC, 0, 0, 0);
    // R7 reserved writes have no effect
    access(1, 8'h08, 32'hDEAD_BEEF, 0, 0);
    access(0, 8'h08, 0, 0, 0);
    access(0, 8'h04, 0, 0, 0);
    // R10 increment with wrap
    access(1, 8'h00, 32'h1, 0, 0);
    access(1, 8'h04, 32'hFFFF_FFFC, 0, 0);
    access(1, 8'h0C, 32'h0BAD_F00D, 2, 0);
    access(0, 8'h04, 0, 0, 0);                 // R10 wraps to 0
    // R5 banked leaves target alone
    access(1, 8'h04, 32'h2000_1238, 0, 0);
    access(0, 8'h18, 0, 1, 32'h5A5A_0001);
    access(0, 8'h04, 0, 0, 0);
    // R1 port mismatch
    req(1, 4'h3, 8'h04, 32'h7777_7777);
    check("R1 no rsp", {31'b0, dp_rsp_valid}, 32'd0);
    check("R1 no launch", {31'b0, mb_valid}, 32'd0);
    req(0, 4'h3, 8'h0C, 0);
    check("R1 no launch data", {31'b0, mb_valid}, 32'd0);
    access(0, 8'h04, 0, 0, 0);
    // R9 busy handling
    req(0, PN, 8'h0C, 0);
    check("R9 launched", {31'b0, mb_valid}, 32'd1);
    req(0, PN, 8'h14, 0);
    check("R9 bank wait", {31'b0, dp_rsp_wait}, 32'd1);
    check("R9 wait rdata", dp_rsp_rdata, 32'h0);
    req(1, PN, 8'h04, 32'h0000_0100);
    check("R9 target write wait", {31'b0, dp_rsp_wait}, 32'd1);
    req(0, PN, 8'h00, 0);
    check("R9 mode read served", {31'b0, dp_rsp_wait}, 32'd0);
    check("R2 busy bit", dp_rsp_rdata, {24'h0, 1'b1, 5'h0, m_mode});
    check("R9 bus addr kept", mb_addr, m_tar);
    serve(1, 32'hCAFE_0042);
    m_rbuf = 32'hCAFE_0042;
    if (m_mode == 2'b01) m_tar = m_tar + 4;
    access(0, 8'h04, 0, 0, 0);
    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a = pick_addr(int'($urandom % 13));
      bit wr = $urandom[0];
      logic [31:0] wd = $urandom;
      if ($urandom % 10 == 0) begin
        req(wr, PN ^ 4'h5, a, wd);
        check("R1 random mismatch", {31'b0, dp_rsp_valid}, 32'd0);
      end else begin
        access(wr, a, wd, int'($urandom % 4), $urandom);
      end
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule